// File: doc/BRIEF.md
# Inbound Message Mailbox

This block is a 32-bit memory-mapped mailbox through which a processor receives messages sent by a coprocessor. The coprocessor loads words into an eight-entry first-in first-out queue through a single-cycle push port. The processor reaches the queue over a simple register bus with an 8-bit byte offset, read and write strobes, byte enables and 32-bit write data. It can remove the oldest message, look at the oldest message without removing it, read a status word, and program an interrupt enable.

The read data path is combinational in the cycle of the read strobe. Any side effect of a read, such as a pop, takes effect at the clock edge that ends that cycle. The interrupt output is a level. It stays high while the enable is set and the queue holds at least one message. Empty queue slots always hold the sentinel word 0xFFFFFFFF, so a read from an empty queue returns that sentinel.

Top module: `inbox_mailbox`

## Requirements
- R1: After reset the queue is empty, the status word reads 0x40000000, the config word reads 0, the interrupt is low and a peek returns 0xFFFFFFFF.
- R2: A full-width read at offset 0x80, 0x84, 0x88 or 0x8C returns the oldest queued word and removes it. The remaining words keep their arrival order.
- R3: A pop read while the queue is empty returns 0xFFFFFFFF and leaves the queue empty.
- R4: A full-width read at offset 0x90 returns the oldest queued word and does not remove it.
- R5: The status word at offset 0x98 has bit 31 set when 8 words are queued and bit 30 set when none are queued. All of its other bits read 0.
- R6: A full-width write to the config word at offset 0x9C updates only bit 0, the interrupt enable. All other written bits are ignored.
- R7: Config bit 4 reads 1 exactly when the queue is not empty. The interrupt output is high exactly when config bits 0 and 4 are both 1.
- R8: After a pop, the slot it vacates holds 0xFFFFFFFF. Removing the last word therefore makes a peek return 0xFFFFFFFF.
- R9: An access whose byte enables are not all 1 is ignored. Such a read returns 0 and pops nothing, and such a write changes nothing.
- R10: Reads of undecoded offsets, offset 0x94 included, return 0. Writes to any offset other than 0x9C have no effect.
- R11: A push while 8 words are queued is dropped and leaves the queue contents unchanged.
- R12: A push in the same cycle as a pop of a full queue is accepted. The queue stays full, and the new word becomes the newest entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte offset of the register access |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| byteEn | input | 4 | Byte enables; only 4'hF is accepted |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rdEn |
| pushValid | input | 1 | Coprocessor push strobe |
| pushData | input | 32 | Coprocessor message word |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The bench fills the queue to the brim and pushes once more. A design that overwrote the tail or wrapped its count would return a foreign word or the wrong number of words while draining. It pops the queue down to nothing and then peeks and pops again. Here a design that left a stale word in the vacated slot would hand back old data instead of the sentinel. It also pushes and pops a full queue in the same cycle, which a design that checked fullness before the pop would reject. Partial-width accesses, writes to the read-only offsets, and writes carrying set bits beyond the enable are each followed by status, peek and config reads, which expose any stray pop, push or config change.

// File: rtl/inbox_pkg.sv
package inbox_pkg;
  localparam int DATA_W = 32;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [DATA_W-1:0] EMPTY_WORD = '1;

  localparam logic [7:0] OFF_PEEK = 8'h90;
  localparam logic [7:0] OFF_STATUS = 8'h98;
  localparam logic [7:0] OFF_CONFIG = 8'h9C;

  typedef struct packed {
    logic popReq;
    logic cfgWr;
    logic selHead;
    logic selStatus;
    logic selConfig;
  } ctrlStrobes_t;
endpackage

// File: rtl/inbox_ctrl.sv
module inbox_ctrl
  import inbox_pkg::*;
(
  input  logic [7:0] addr,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [3:0] byteEn,
  output ctrlStrobes_t strobes
);
  logic wordAcc;
  logic rdOk;
  logic isPopOff;

  assign wordAcc = (byteEn == 4'hF);
  assign rdOk = rdEn && wordAcc;
  assign isPopOff = (addr[7:4] == 4'h8) && (addr[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    strobes.popReq = rdOk && isPopOff;
    strobes.selHead = rdOk && (isPopOff || addr == OFF_PEEK);
    strobes.selStatus = rdOk && (addr == OFF_STATUS);
    strobes.selConfig = rdOk && (addr == OFF_CONFIG);
    strobes.cfgWr = wrEn && wordAcc && (addr == OFF_CONFIG);
  end
endmodule

// File: rtl/inbox_datapath.sv
module inbox_datapath
  import inbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              cfgBit,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              queueEmpty
);
  logic [DATA_W-1:0] slot [DEPTH];
  logic [DATA_W-1:0] slotNext [DEPTH];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countAfterPop;
  logic doPop;
  logic doPush;
  logic isFull;
  logic irqEn;
  logic pending;

  assign isFull = (count == CNT_W'(DEPTH));
  assign queueEmpty = (count == '0);
  assign doPop = strobes.popReq && !queueEmpty;
  assign doPush = pushValid && (!isFull || doPop);
  assign countAfterPop = count - CNT_W'(doPop);
  assign pending = !queueEmpty;

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic [DATA_W-1:0] shifted;
    if (i == DEPTH - 1) begin : gLast
      assign shifted = doPop ? EMPTY_WORD : slot[i];
    end else begin : gMid
      assign shifted = doPop ? slot[i+1] : slot[i];
    end
    assign slotNext[i] = (doPush && countAfterPop == CNT_W'(i)) ? pushData : shifted;

    always_ff @(posedge clk) begin
      if (!rstN) slot[i] <= EMPTY_WORD;
      else       slot[i] <= slotNext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      irqEn <= 1'b0;
    end else begin
      count <= countAfterPop + CNT_W'(doPush);
      if (strobes.cfgWr) irqEn <= cfgBit;
    end
  end

  always_comb begin
    rdata = '0;
    if (strobes.selHead) rdata = slot[0];
    else if (strobes.selStatus) rdata = {isFull, queueEmpty, 30'b0};
    else if (strobes.selConfig) rdata = {27'b0, pending, 3'b0, irqEn};
  end

  assign irq = irqEn && pending;

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && pushValid && !strobes.popReq) |=> ($stable(count) && slot[DEPTH-1] == $past(slot[DEPTH-1])));

  a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popReq && !pushValid && count != '0) |=> (count == $past(count) - 1'b1 && slot[0] == $past(slot[1])));

  a_r8_vacated_sentinel: assert property (@(posedge clk) disable iff (!rstN)
    (!isFull) |-> (slot[DEPTH-1] == EMPTY_WORD));

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isFull, queueEmpty}));

  a_r12_full_swap: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && strobes.popReq && pushValid) |=> (isFull && slot[DEPTH-1] == $past(pushData)));
endmodule

// File: rtl/inbox_mailbox.sv
module inbox_mailbox
  import inbox_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  addr,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [3:0]  byteEn,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        pushValid,
  input  logic [31:0] pushData,
  output logic        irq
);
  ctrlStrobes_t strobes;
  logic queueEmpty;
  logic unusedWdata;

  assign unusedWdata = ^wdata[31:1];

  inbox_ctrl uCtrl (
    .addr    (addr),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .byteEn  (byteEn),
    .strobes (strobes)
  );

  inbox_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgBit     (wdata[0]),
    .pushValid  (pushValid),
    .pushData   (pushData),
    .rdata      (rdata),
    .irq        (irq),
    .queueEmpty (queueEmpty)
  );

  a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !queueEmpty);
endmodule

// File: tb/tb_inbox_mailbox.sv
module tb_inbox_mailbox;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addr = '0;
  logic rdEn = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] byteEn = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic pushValid = 1'b0;
  logic [31:0] pushData = '0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] SENT = 32'hFFFF_FFFF;

  always #10 clk = ~clk;

  inbox_mailbox dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .byteEn(byteEn), .wdata(wdata), .rdata(rdata),
    .pushValid(pushValid), .pushData(pushData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1; byteEn = be;
    #5 d = rdata;
    @(posedge clk); #1;
    rdEn = 1'b0; byteEn = 4'hF;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] v);
    @(negedge clk);
    addr = a; wrEn = 1'b1; byteEn = be; wdata = v;
    @(posedge clk); #1;
    wrEn = 1'b0; byteEn = 4'hF;
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk);
    pushValid = 1'b1; pushData = v;
    @(posedge clk); #1;
    pushValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tReset();
    logic [31:0] d;
    doReset();
    rd(8'h98, 4'hF, d); check("R1 status", d, 32'h4000_0000);
    rd(8'h9C, 4'hF, d); check("R1 config", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h90, 4'hF, d); check("R1 peek", d, SENT);
  endtask

  task automatic tOrder();
    logic [31:0] d;
    doReset();
    push(32'hA0A0_0001); push(32'hB0B0_0002); push(32'hC0C0_0003);
    rd(8'h90, 4'hF, d); check("R4 peek", d, 32'hA0A0_0001);
    rd(8'h90, 4'hF, d); check("R4 peek again", d, 32'hA0A0_0001);
    rd(8'h80, 4'hF, d); check("R2 pop 0x80", d, 32'hA0A0_0001);
    rd(8'h84, 4'hF, d); check("R2 pop 0x84", d, 32'hB0B0_0002);
    rd(8'h8C, 4'hF, d); check("R2 pop 0x8C", d, 32'hC0C0_0003);
    rd(8'h98, 4'hF, d); check("R2 empty after drain", d, 32'h4000_0000);
  endtask

  task automatic tEmpty();
    logic [31:0] d;
    doReset();
    rd(8'h88, 4'hF, d); check("R3 empty pop", d, SENT);
    rd(8'h98, 4'hF, d); check("R3 still empty", d, 32'h4000_0000);
    push(32'h1234_5678);
    rd(8'h80, 4'hF, d); check("R8 pop single", d, 32'h1234_5678);
    rd(8'h90, 4'hF, d); check("R8 vacated slot", d, SENT);
  endtask

  task automatic tFull();
    logic [31:0] d;
    doReset();
    for (int i = 0; i < 8; i++) push(32'h5500_0000 + i);
    rd(8'h98, 4'hF, d); check("R5 full flag", d, 32'h8000_0000);
    push(32'hDEAD_BEEF);
    rd(8'h98, 4'hF, d); check("R11 still full", d, 32'h8000_0000);
    for (int i = 0; i < 8; i++) begin
      rd(8'h80, 4'hF, d); check("R11 drain order", d, 32'h5500_0000 + i);
    end
    rd(8'h80, 4'hF, d); check("R11 no extra word", d, SENT);
  endtask

  task automatic tSwap();
    logic [31:0] d;
    doReset();
    for (int i = 0; i < 8; i++) push(32'h7700_0000 + i);
    @(negedge clk);
    addr = 8'h80; rdEn = 1'b1; pushValid = 1'b1; pushData = 32'h7700_00AA;
    #5 d = rdata;
    @(posedge clk); #1;
    rdEn = 1'b0; pushValid = 1'b0;
    check("R12 swap pop value", d, 32'h7700_0000);
    rd(8'h98, 4'hF, d); check("R12 still full", d, 32'h8000_0000);
    for (int i = 1; i < 8; i++) begin
      rd(8'h84, 4'hF, d); check("R12 drain", d, 32'h7700_0000 + i);
    end
    rd(8'h84, 4'hF, d); check("R12 newest last", d, 32'h7700_00AA);
  endtask

  task automatic tConfig();
    logic [31:0] d;
    doReset();
    wr(8'h9C, 4'hF, 32'hFFFF_FFFE);
    rd(8'h9C, 4'hF, d); check("R6 only bit0", d, 32'h0);
    wr(8'h9C, 4'hF, 32'hFFFF_FFFF);
    rd(8'h9C, 4'hF, d); check("R6 enable set", d, 32'h1);
    check("R7 irq low empty", {31'b0, irq}, 32'h0);
    push(32'h0000_0042);
    rd(8'h9C, 4'hF, d); check("R7 pending", d, 32'h11);
    check("R7 irq high", {31'b0, irq}, 32'h1);
    wr(8'h9C, 4'hF, 32'h0);
    rd(8'h9C, 4'hF, d); check("R7 disabled", d, 32'h10);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h9C, 4'hF, 32'h1);
    check("R7 irq re-enabled", {31'b0, irq}, 32'h1);
    rd(8'h80, 4'hF, d);
    rd(8'h9C, 4'hF, d); check("R7 pending clears", d, 32'h1);
    check("R7 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic tPartial();
    logic [31:0] d;
    doReset();
    push(32'hCAFE_0001);
    rd(8'h80, 4'h3, d); check("R9 partial read data", d, 32'h0);
    rd(8'h90, 4'hF, d); check("R9 no pop", d, 32'hCAFE_0001);
    wr(8'h9C, 4'h1, 32'h1);
    rd(8'h9C, 4'hF, d); check("R9 partial write", d, 32'h10);
  endtask

  task automatic tUndecoded();
    logic [31:0] d;
    doReset();
    push(32'hBEEF_0007);
    rd(8'h94, 4'hF, d); check("R10 read 0x94", d, 32'h0);
    rd(8'hA0, 4'hF, d); check("R10 read 0xA0", d, 32'h0);
    rd(8'h81, 4'hF, d); check("R10 unaligned", d, 32'h0);
    wr(8'h80, 4'hF, 32'h1111_1111);
    wr(8'h98, 4'hF, 32'hFFFF_FFFF);
    wr(8'h94, 4'hF, 32'h1);
    rd(8'h9C, 4'hF, d); check("R10 config untouched", d, 32'h10);
    rd(8'h80, 4'hF, d); check("R10 head intact", d, 32'hBEEF_0007);
    rd(8'h98, 4'hF, d); check("R10 no push by write", d, 32'h4000_0000);
  endtask

  initial begin
    tReset();
    tOrder();
    tEmpty();
    tFull();
    tSwap();
    tConfig();
    tPartial();
    tUndecoded();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule